// File: doc/BRIEF.md
# Redundant check-event filter

The filter sits between a stream of monitoring events and a software checker. Check events whose outcome cannot have changed since the same event last passed are removed, so the checker only sees new work. Each event carries a kind and an address. The pair is the tag held in a small fully associative store. A check event that matches a live entry is accepted and dropped. A check event that matches nothing is forwarded downstream and written into the store in the same cycle.

Some event kinds change the metadata the checker depends on, such as allocation or release. A mask input marks these kinds as invalidating. An invalidating event is always forwarded and never stored. It clears either the whole store or only the entries whose address falls in a window, as chosen by a mode input. A second, remote clear port lets another monitoring lane clear the store, in full or by window, with no handshake.

Top module: `evf_filter`

## Requirements
- R1: After reset the output is empty (out_valid_o = 0), in_ready_o = 1 and no entry is live, so the first event of every tag is forwarded.
- R2: An accepted check event that misses is presented on out_kind_o/out_addr_o with out_valid_o = 1 on the next cycle, and is stored.
- R3: An accepted check event whose kind and address match a live entry is dropped and produces no output.
- R4: The tag is kind and address together: the same address with a different kind is a miss.
- R5: An event whose kind k has inv_kind_mask_i[k] = 1 is forwarded and never stored; with inv_partial_i = 0 it clears every entry.
- R6: With inv_partial_i = 1, an invalidating event clears only entries with in_addr_i <= addr < in_addr_i + in_len_i, computed without wrap; other entries stay live.
- R7: In any cycle with rinv_valid_i = 1, the store is cleared in full when rinv_full_i = 1, otherwise over rinv_base_i <= addr < rinv_base_i + rinv_len_i.
- R8: A clear in the same cycle as a lookup takes effect first: the lookup sees the cleared state and misses.
- R9: in_ready_o = 1 exactly when the output is empty or out_ready_i = 1; while out_valid_o = 1 and out_ready_i = 0 the output holds steady, and no event is lost or repeated.
- R10: The store holds NUM_ENTRIES (default 16) tags, replaced in round-robin order starting at slot 0: with an empty store, the 17th distinct miss evicts the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Incoming event valid |
| in_ready_o | output | 1 | Filter can accept an event |
| in_kind_i | input | KIND_W | Event kind |
| in_addr_i | input | ADDR_W | Event address; window base for a windowed clear |
| in_len_i | input | ADDR_W | Window length for a windowed clear |
| inv_kind_mask_i | input | 2**KIND_W | Bit k set marks kind k as invalidating |
| inv_partial_i | input | 1 | 1: invalidating events clear a window, 0: clear all |
| rinv_valid_i | input | 1 | Remote clear request this cycle |
| rinv_full_i | input | 1 | Remote clear of every entry |
| rinv_base_i | input | ADDR_W | Remote window base |
| rinv_len_i | input | ADDR_W | Remote window length |
| out_valid_o | output | 1 | Forwarded event valid |
| out_ready_i | input | 1 | Checker accepts the forwarded event |
| out_kind_o | output | KIND_W | Forwarded event kind |
| out_addr_o | output | ADDR_W | Forwarded event address |

## Verification
On every cycle, assertions check that the output holds steady under back-pressure, that a miss appears one cycle later and a hit produces nothing, and that no two live entries share a tag. They also check that a remote full clear empties the store and that the replacement pointer advances by one slot per insertion. Only the bench scenarios can show that a window clears exactly the entries it should, keeping the one at its upper bound. The same holds for the store's replacement order when full, a clear winning over a lookup in the same cycle, and whole streams arriving in order with nothing lost or repeated under stalls.

// File: rtl/evf_pkg.sv
package evf_pkg;
  typedef enum logic {
    CLR_ALL = 1'b0,
    CLR_WIN = 1'b1
  } clr_mode_e;
endpackage

// File: rtl/evf_win.sv
module evf_win #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] len_i,
  output logic              in_o
);
  localparam int EW = ADDR_W + 1;
  logic [EW-1:0] a_x, lo_x, hi_x;
  assign a_x  = {1'b0, addr_i};
  assign lo_x = {1'b0, base_i};
  assign hi_x = lo_x + {1'b0, len_i};  // no wrap: one extra bit
  assign in_o = (a_x >= lo_x) && (a_x < hi_x);
endmodule

// File: rtl/evf_slot.sv
module evf_slot #(
  parameter int ADDR_W = 32,
  parameter int KIND_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              kill_i,
  input  logic [KIND_W-1:0] wr_kind_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [KIND_W-1:0] lk_kind_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              valid_o,
  output logic              match_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [KIND_W-1:0] kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      kind_q  <= '0;
      addr_q  <= '0;
    end else if (wr_i) begin
      valid_q <= 1'b1;
      kind_q  <= wr_kind_i;
      addr_q  <= wr_addr_i;
    end else if (kill_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign match_o = valid_q && (kind_q == lk_kind_i) && (addr_q == lk_addr_i);

  // R2
  wr_sets_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> valid_o && (addr_o == $past(wr_addr_i)));
endmodule

// File: rtl/evf_rr.sv
module evf_rr #(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                                        clk_i,
  input  logic                                        rst_ni,
  input  logic                                        adv_i,
  output logic [(NUM_ENTRIES > 1 ? $clog2(NUM_ENTRIES) : 1)-1:0] ptr_o
);
  localparam int PW = NUM_ENTRIES > 1 ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [PW-1:0] LAST = PW'(NUM_ENTRIES - 1);
  logic [PW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end
  assign ptr_o = ptr_q;

  // R10
  rr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> ptr_o == (($past(ptr_o) == LAST) ? '0 : $past(ptr_o) + 1'b1));
  // R10
  rr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_o));
endmodule

// File: rtl/evf_filter.sv
module evf_filter
  import evf_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int KIND_W      = 3,
  parameter int NUM_ENTRIES = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [KIND_W-1:0]    in_kind_i,
  input  logic [ADDR_W-1:0]    in_addr_i,
  input  logic [ADDR_W-1:0]    in_len_i,
  input  logic [2**KIND_W-1:0] inv_kind_mask_i,
  input  logic                 inv_partial_i,
  input  logic                 rinv_valid_i,
  input  logic                 rinv_full_i,
  input  logic [ADDR_W-1:0]    rinv_base_i,
  input  logic [ADDR_W-1:0]    rinv_len_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [KIND_W-1:0]    out_kind_o,
  output logic [ADDR_W-1:0]    out_addr_o
);
  localparam int PW = NUM_ENTRIES > 1 ? $clog2(NUM_ENTRIES) : 1;

  logic              fire, is_inv, loc_inv, loc_all, loc_win, rem_all, rem_win;
  logic              hit_eff, insert, fwd;
  clr_mode_e         loc_mode;
  logic [PW-1:0]     ptr;
  logic [NUM_ENTRIES-1:0] valid_v, match_v, kill_v, wr_v;
  logic              out_valid_q;
  logic [KIND_W-1:0] out_kind_q;
  logic [ADDR_W-1:0] out_addr_q;

  assign in_ready_o = !out_valid_q || out_ready_i;
  assign fire       = in_valid_i && in_ready_o;
  assign is_inv     = inv_kind_mask_i[in_kind_i];
  assign loc_mode   = clr_mode_e'(inv_partial_i);
  assign loc_inv    = fire && is_inv;
  assign loc_all    = loc_inv && (loc_mode == CLR_ALL);
  assign loc_win    = loc_inv && (loc_mode == CLR_WIN);
  assign rem_all    = rinv_valid_i && rinv_full_i;
  assign rem_win    = rinv_valid_i && !rinv_full_i;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
    logic [ADDR_W-1:0] s_addr;
    logic              in_loc, in_rem;

    evf_win #(.ADDR_W(ADDR_W)) u_win_loc (
      .addr_i(s_addr), .base_i(in_addr_i), .len_i(in_len_i), .in_o(in_loc));
    evf_win #(.ADDR_W(ADDR_W)) u_win_rem (
      .addr_i(s_addr), .base_i(rinv_base_i), .len_i(rinv_len_i), .in_o(in_rem));

    assign kill_v[i] = loc_all || rem_all || (loc_win && in_loc) || (rem_win && in_rem);
    assign wr_v[i]   = insert && (ptr == PW'(i));

    evf_slot #(.ADDR_W(ADDR_W), .KIND_W(KIND_W)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_v[i]),
      .kill_i   (kill_v[i]),
      .wr_kind_i(in_kind_i),
      .wr_addr_i(in_addr_i),
      .lk_kind_i(in_kind_i),
      .lk_addr_i(in_addr_i),
      .valid_o  (valid_v[i]),
      .match_o  (match_v[i]),
      .addr_o   (s_addr)
    );
  end

  // same-cycle clears win over the lookup
  assign hit_eff = |(match_v & ~kill_v);
  assign insert  = fire && !is_inv && !hit_eff;
  assign fwd     = fire && (is_inv || !hit_eff);

  evf_rr #(.NUM_ENTRIES(NUM_ENTRIES)) u_rr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(insert), .ptr_o(ptr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_kind_q  <= '0;
      out_addr_q  <= '0;
    end else if (fwd) begin
      out_valid_q <= 1'b1;
      out_kind_q  <= in_kind_i;
      out_addr_q  <= in_addr_i;
    end else if (out_ready_i) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_kind_o  = out_kind_q;
  assign out_addr_o  = out_addr_q;

  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_addr_o) && $stable(out_kind_o));
  // R3
  hit_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !is_inv && hit_eff |=> !out_valid_o);
  // R2
  miss_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !is_inv && !hit_eff |=> out_valid_o && out_addr_o == $past(in_addr_i)
                                    && out_kind_o == $past(in_kind_i));
  // R4
  unique_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_v));
  // R7
  remote_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_all && !insert |=> valid_v == '0);
endmodule

// File: tb/tb_evf_filter.sv
`timescale 1ns/1ps
module tb_evf_filter;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, out_ready = 1, inv_partial = 0;
  logic [2:0]  in_kind = 0;
  logic [31:0] in_addr = 0, in_len = 0;
  logic [7:0]  inv_mask = 8'b0110_0000;  // kinds 5 and 6 invalidate
  logic        rinv_valid = 0, rinv_full = 0;
  logic [31:0] rinv_base = 0, rinv_len = 0;
  logic        in_ready_o, out_valid_o;
  logic [2:0]  out_kind_o;
  logic [31:0] out_addr_o;

  int checks = 0, fails = 0, fwd_cnt = 0;
  bit done = 0;
  logic [34:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  evf_filter dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready_o),
    .in_kind_i(in_kind), .in_addr_i(in_addr), .in_len_i(in_len),
    .inv_kind_mask_i(inv_mask), .inv_partial_i(inv_partial),
    .rinv_valid_i(rinv_valid), .rinv_full_i(rinv_full),
    .rinv_base_i(rinv_base), .rinv_len_i(rinv_len),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready),
    .out_kind_o(out_kind_o), .out_addr_o(out_addr_o));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected item on each transfer
  always @(negedge clk) begin
    if (rst_n && out_valid_o && out_ready) begin
      fwd_cnt++;
      if (exp_q.size() == 0) check(0, "R3 unexpected output", {29'd0, out_kind_o, out_addr_o}, 0);
      else begin
        logic [34:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({out_kind_o, out_addr_o} == e, t, {29'd0, out_kind_o, out_addr_o}, {29'd0, e});
      end
    end
  end

  task automatic send(input logic [2:0] k, input logic [31:0] a, input logic [31:0] l,
                      input bit fwd, input string tag,
                      input bit rv = 0, input bit rf = 0,
                      input logic [31:0] rb = 0, input logic [31:0] rl = 0);
    bit r;
    @(posedge clk); #2;
    in_valid = 1; in_kind = k; in_addr = a; in_len = l;
    rinv_valid = rv; rinv_full = rf; rinv_base = rb; rinv_len = rl;
    if (fwd) begin exp_q.push_back({k, a}); tag_q.push_back(tag); end
    forever begin
      @(negedge clk); r = in_ready_o;
      @(posedge clk); #2; rinv_valid = 0;
      if (r) break;
    end
    in_valid = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_drop(input logic [2:0] k, input logic [31:0] a, input string tag);
    int n;
    drain();
    n = fwd_cnt;
    send(k, a, 0, 0, tag);
    repeat (4) @(negedge clk);
    check(fwd_cnt == n, tag, fwd_cnt, n);
  endtask

  task automatic remote(input bit full, input logic [31:0] b, input logic [31:0] l);
    @(posedge clk); #2;
    rinv_valid = 1; rinv_full = full; rinv_base = b; rinv_len = l;
    @(posedge clk); #2;
    rinv_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk); #2; rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(out_valid_o == 0, "R1 out_valid after reset", out_valid_o, 0);
    check(in_ready_o == 1, "R1 in_ready after reset", in_ready_o, 1);

    // R2 miss forwarded, R3 repeat dropped
    send(0, 32'h40, 0, 1, "R2 first miss");
    expect_drop(0, 32'h40, "R3 repeat dropped");
    // R4 same address other kind misses
    send(1, 32'h40, 0, 1, "R4 kind in tag");
    expect_drop(1, 32'h40, "R3 repeat kind1 dropped");

    // R5 full clear by invalidating kind, itself forwarded and not stored
    inv_partial = 0;
    send(5, 32'h999, 0, 1, "R5 invalidator forwarded");
    send(0, 32'h40, 0, 1, "R5 entry cleared");
    send(5, 32'h999, 0, 1, "R5 invalidator not stored");

    // R6 windowed clear [0x18,0x28)
    remote(1, 0, 0);
    send(1, 32'h10, 0, 1, "R6 fill");
    send(1, 32'h20, 0, 1, "R6 fill");
    send(1, 32'h28, 0, 1, "R6 fill");
    send(1, 32'h30, 0, 1, "R6 fill");
    inv_partial = 1;
    send(6, 32'h18, 32'h10, 1, "R6 window invalidator");
    expect_drop(1, 32'h10, "R6 below window kept");
    send(1, 32'h20, 0, 1, "R6 inside window cleared");
    expect_drop(1, 32'h28, "R6 upper bound kept");
    expect_drop(1, 32'h30, "R6 above window kept");

    // R7 remote windowed and full clear
    remote(0, 32'h30, 32'h1);
    send(1, 32'h30, 0, 1, "R7 remote window cleared");
    expect_drop(1, 32'h10, "R7 remote window kept other");
    remote(1, 0, 0);
    send(1, 32'h10, 0, 1, "R7 remote full cleared");

    // R8 clear beats same-cycle lookup
    drain();
    send(2, 32'h77, 0, 1, "R8 fill");
    drain();
    send(2, 32'h77, 0, 1, "R8 clear before lookup", 1, 1, 0, 0);
    drain();
    send(2, 32'h88, 0, 1, "R8 fill");
    drain();
    send(2, 32'h88, 0, 1, "R8 window clear before lookup", 1, 0, 32'h80, 32'h10);

    // R9 back-pressure
    drain();
    out_ready = 0;
    send(3, 32'h500, 0, 1, "R9 stalled A");
    fork
      send(3, 32'h504, 0, 1, "R9 stalled B");
      begin
        repeat (5) @(negedge clk);
        check(in_ready_o == 0, "R9 ready low while stalled", in_ready_o, 0);
        check(out_valid_o && out_addr_o == 32'h500, "R9 output held", out_addr_o, 32'h500);
        @(posedge clk); #2; out_ready = 1;
      end
    join
    drain();

    // R10 round robin eviction
    remote(1, 0, 0);
    for (int i = 0; i < 17; i++) send(4, 32'h1000 + i, 0, 1, "R10 fill");
    expect_drop(4, 32'h1001, "R10 second entry kept");
    send(4, 32'h1000, 0, 1, "R10 first entry evicted");

    drain();
    check(exp_q.size() == 0, "R9 no event lost", exp_q.size(), 0);
    finish_run();
  end
endmodule